// File: doc/BRIEF.md
# Per-Channel Rise-Time and Timestamp Capture Counter

One copy of this block sits in each detector channel. Two comparator levels come in without a clock relationship. The first comes from a fast threshold comparator and marks the start of a pulse. The second comes from the energy threshold and marks the end of the rise. Each level passes through a two-flop synchronizer, and a rising-edge detector follows. The block counts clock cycles between the start edge and the stop edge. The count gives a digitised rise time, which the downstream chain uses to correct amplitude loss that depends on interaction depth. At the start edge the block also captures a free-running cycle counter as a timestamp. The rise-time count and the timestamp each have their own resolution setting: a 2-bit code divides the count rate by 1, 2, 4 or 8.

A result, once captured, is held and flagged as valid until the readout logic acknowledges it. The acknowledge clears the result and re-arms the channel. Start edges that arrive while a measurement is running, or while a result is waiting to be read, are discarded. This keeps a pile-up from corrupting a result that is half read. With a 32 MHz clock one count is 31.25 ns, so a rise of about 100 ns reads as about 3 counts and one of about 800 ns as about 26.

A control state machine has three named states:
- `ST_IDLE`: armed.
- `ST_COUNT`: measuring.
- `ST_HOLD`: result waiting.

It has three named transitions:
- ARM (`ST_IDLE` to `ST_COUNT`): taken on a detected start edge.
- STOP (`ST_COUNT` to `ST_HOLD`): taken on a detected stop edge.
- RELEASE (`ST_HOLD` to `ST_IDLE`): taken when the acknowledge is seen while holding.

Top module: `rt_ts_capture`

## Requirements
- R1: While reset is held, and after it, until the first measurement, `valid_o` is 0 and `rise_o` and `stamp_o` are 0.
- R2: A comparator input that rises takes effect on the third rising clock edge at which it is sampled. `valid_o` rises on the third edge after `energy_cmp_i` goes high, and not on the two edges before it.
- R3: If the stop input rises d clock cycles after the start input (d ≥ 1), the result is `rise_o` = floor(d / 2^`rt_res_i`). The codes of `rt_res_i` are 0, 1, 2 and 3, and they give divide-by 1, 2, 4 and 8.
- R4: The rise-time count saturates at 2^RT_W − 1 (255 by default) instead of wrapping.
- R5: A free-running counter is cleared by reset and counts one per clock edge. The count before the edge at which the start is acted on is taken as `stamp_o`, after a right shift by `ts_res_i`, a value from 0 to 3. Only the low TS_W bits are kept.
- R6: While `valid_o` is 1 and `rd_ack_i` is 0, `valid_o`, `rise_o` and `stamp_o` hold their values.
- R7: When `rd_ack_i` is 1 while `valid_o` is 1, `valid_o`, `rise_o` and `stamp_o` are all 0 after the next edge, and the channel re-arms.
- R8: A new start edge arriving during a measurement or while a result is held is ignored. It changes neither the held timestamp nor the rise count.
- R9: A stop edge seen while the block is armed and idle is ignored, and `valid_o` stays 0.
- R10: A comparator level that stays high does not retrigger. After a release, a start that is still held high starts no new measurement until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock (32 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_cmp_i | input | 1 | Asynchronous fast-shaper comparator level; its rising edge starts a measurement |
| energy_cmp_i | input | 1 | Asynchronous energy-threshold level; its rising edge ends the rise |
| rt_res_i | input | RES_W | Rise-time prescale code (divide by 2^code) |
| ts_res_i | input | RES_W | Timestamp prescale code (right shift by code) |
| rd_ack_i | input | 1 | Readout acknowledge; clears a held result |
| valid_o | output | 1 | A captured result is held |
| rise_o | output | RT_W | Digitised rise time |
| stamp_o | output | TS_W | Captured timestamp |

## Verification
Both comparator paths have three register stages: two synchronizer flops and one edge-detect flop. The start therefore takes effect on the third edge after it is driven. The stop sets `valid_o` on the third edge after it is driven, and the rise count and the timestamp become visible on that same edge. The bench drives every input on a falling edge and samples two falling edges after driving the stop, where `valid_o` must still be low. It samples again one edge later for the valid flag, the count and the stamp. The expected timestamp is the bench's own count of edges since reset at the moment the start is driven, plus two. Release is checked one edge after the acknowledge.

// File: rtl/rt_pkg.sv
package rt_pkg;

    // Control states of the capture channel
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } cap_state_t;

endpackage

// File: rtl/rt_edge_sync.sv
// Multi-stage synchronizer followed by a rising-edge detector.
module rt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], d_i};
    end

    // Last synchronized stage high, edge-detect stage still low
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/rt_prescale.sv
// Programmable divide-by-2^res tick generator.
module rt_prescale #(
    parameter int RES_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [RES_W-1:0] res_i,
    output logic             tick_o
);
    localparam int PRE_W = (1 << RES_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] wrap_at;

    always_comb begin
        wrap_at = PRE_W'((1 << res_i) - 1);
        tick_o  = en_i && (pre_q == wrap_at);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     pre_q <= '0;
        else if (clr_i) pre_q <= '0;
        else if (en_i)  pre_q <= tick_o ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/rt_sat_count.sv
// Counter that stops at its all-ones value.
module rt_sat_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)                    q_o <= '0;
        else if (clr_i)                q_o <= '0;
        else if (inc_i && q_o != '1)   q_o <= q_o + 1'b1;
    end
endmodule

// File: rtl/rt_ts_capture.sv
module rt_ts_capture
    import rt_pkg::*;
#(
    parameter int RT_W        = 8,
    parameter int TS_W        = 16,
    parameter int RES_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_cmp_i,
    input  logic             energy_cmp_i,
    input  logic [RES_W-1:0] rt_res_i,
    input  logic [RES_W-1:0] ts_res_i,
    input  logic             rd_ack_i,
    output logic             valid_o,
    output logic [RT_W-1:0]  rise_o,
    output logic [TS_W-1:0]  stamp_o
);
    localparam int MAX_SHIFT = (1 << RES_W) - 1;
    localparam int FREE_W    = TS_W + MAX_SHIFT;
    localparam int NUM_CMP   = 2;
    localparam int IDX_START = 0;
    localparam int IDX_STOP  = 1;

    // ---------------- comparator synchronizers ----------------
    logic [NUM_CMP-1:0] cmp_raw;
    logic [NUM_CMP-1:0] cmp_rise;

    assign cmp_raw = {energy_cmp_i, fast_cmp_i};

    generate
        for (genvar g = 0; g < NUM_CMP; g++) begin : g_sync
            rt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .d_i    (cmp_raw[g]),
                .rise_o (cmp_rise[g])
            );
        end
    endgenerate

    logic start_p, stop_p;
    assign start_p = cmp_rise[IDX_START];
    assign stop_p  = cmp_rise[IDX_STOP];

    // ---------------- control state machine ----------------
    cap_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_p)  state_d = ST_COUNT;   // ARM
            ST_COUNT: if (stop_p)   state_d = ST_HOLD;    // STOP
            ST_HOLD:  if (rd_ack_i) state_d = ST_IDLE;    // RELEASE
            default:                state_d = ST_IDLE;
        endcase
    end

    logic arm, release_now;
    assign arm         = (state_q == ST_IDLE) && start_p;
    assign release_now = (state_q == ST_HOLD) && rd_ack_i;

    // ---------------- timestamp ----------------
    logic [FREE_W-1:0] free_q;
    logic [FREE_W-1:0] free_shifted;
    logic [TS_W-1:0]   stamp_q;

    assign free_shifted = free_q >> ts_res_i;

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '0;
        else        free_q <= free_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           stamp_q <= '0;
        else if (release_now) stamp_q <= '0;
        else if (arm)         stamp_q <= free_shifted[TS_W-1:0];
    end

    // ---------------- rise-time count ----------------
    logic cnt_clr, cnt_en, tick;
    logic [RT_W-1:0] rise_q;

    assign cnt_clr = (state_q == ST_IDLE) || release_now;
    assign cnt_en  = (state_q == ST_COUNT);

    rt_prescale #(.RES_W(RES_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .en_i   (cnt_en),
        .res_i  (rt_res_i),
        .tick_o (tick)
    );

    rt_sat_count #(.W(RT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (tick),
        .q_o   (rise_q)
    );

    // ---------------- outputs ----------------
    always_comb begin
        valid_o = (state_q == ST_HOLD);
        rise_o  = rise_q;
        stamp_o = stamp_q;
    end
endmodule

// File: rtl/rt_ts_capture_chk.sv
module rt_ts_capture_chk #(
    parameter int RT_W = 8,
    parameter int TS_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_ack_i,
    input logic            valid_o,
    input logic [RT_W-1:0] rise_o,
    input logic [TS_W-1:0] stamp_o
);
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && rd_ack_i) |=> (!valid_o && rise_o == '0 && stamp_o == '0));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !rd_ack_i) |=> (valid_o && $stable(rise_o) && $stable(stamp_o)));

    // R4
    rise_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o == '1 && !(valid_o && rd_ack_i)) |=> (rise_o == '1));

    // R3
    rise_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && rd_ack_i) |=> (rise_o >= $past(rise_o)));
endmodule

bind rt_ts_capture rt_ts_capture_chk #(.RT_W(RT_W), .TS_W(TS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_ack_i (rd_ack_i),
    .valid_o  (valid_o),
    .rise_o   (rise_o),
    .stamp_o  (stamp_o)
);

// File: tb/tb_rt_ts_capture.sv
module tb_rt_ts_capture;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 20000;
    localparam int NV         = 13;

    typedef struct packed {
        logic [1:0]  rt;
        logic [1:0]  ts;
        logic [10:0] d;
        logic [7:0]  exp_rise;
    } vec_t;

    // rise-time code, timestamp code, start-to-stop cycles, expected count
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 11'd3,    8'd3},
        '{2'd0, 2'd1, 11'd26,   8'd26},
        '{2'd1, 2'd2, 11'd26,   8'd13},
        '{2'd2, 2'd3, 11'd26,   8'd6},
        '{2'd3, 2'd0, 11'd26,   8'd3},
        '{2'd3, 2'd1, 11'd7,    8'd0},
        '{2'd1, 2'd0, 11'd1,    8'd0},
        '{2'd0, 2'd0, 11'd1,    8'd1},
        '{2'd0, 2'd2, 11'd255,  8'd255},
        '{2'd0, 2'd0, 11'd300,  8'd255},
        '{2'd2, 2'd1, 11'd1023, 8'd255},
        '{2'd1, 2'd3, 11'd511,  8'd255},
        '{2'd3, 2'd0, 11'd1000, 8'd125}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast = 1'b0, energy = 1'b0, ack = 1'b0;
    logic [1:0] rt_res = '0, ts_res = '0;
    logic       valid;
    logic [7:0] rise;
    logic [15:0] stamp;

    int n_chk = 0;
    int n_fail = 0;
    int bc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) bc <= 0;
        else        bc <= bc + 1;
    end

    rt_ts_capture dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fast_cmp_i   (fast),
        .energy_cmp_i (energy),
        .rt_res_i     (rt_res),
        .ts_res_i     (ts_res),
        .rd_ack_i     (ack),
        .valid_o      (valid),
        .rise_o       (rise),
        .stamp_o      (stamp)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic measure(input logic [1:0] rt, input logic [1:0] ts,
                           input int d, input int exp_rise);
        int n;
        longint exp_ts;
        @(negedge clk);
        rt_res = rt; ts_res = ts; fast = 1'b1;
        n = bc;
        exp_ts = ((longint'(n) + 2) >> ts) & 16'hFFFF;
        repeat (d) @(negedge clk);
        energy = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 valid before third edge", valid, 0);
        @(negedge clk);
        check("R2 valid on third edge", valid, 1);
        check(exp_rise == 255 ? "R4 saturated rise" : "R3 rise count", rise, exp_rise);
        check("R5 timestamp", stamp, exp_ts);
        repeat (3) @(negedge clk);
        check("R6 held valid", valid, 1);
        check("R6 held rise", rise, exp_rise);
        check("R6 held stamp", stamp, exp_ts);
        fast = 1'b0; energy = 1'b0; ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R7 valid cleared", valid, 0);
        check("R7 rise cleared", rise, 0);
        check("R7 stamp cleared", stamp, 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 reset valid", valid, 0);
        check("R1 reset rise", rise, 0);
        check("R1 reset stamp", stamp, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 idle valid after reset", valid, 0);

        for (int i = 0; i < NV; i++)
            measure(VECS[i].rt, VECS[i].ts, int'(VECS[i].d), int'(VECS[i].exp_rise));

        // R9: stop edge while idle is ignored
        @(negedge clk); energy = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 stop in idle valid", valid, 0);
        check("R9 stop in idle rise", rise, 0);
        energy = 1'b0;
        repeat (4) @(negedge clk);

        // R8: restart during count and during hold is ignored
        @(negedge clk);
        rt_res = 2'd0; ts_res = 2'd0; fast = 1'b1; n = bc;
        repeat (2) @(negedge clk); fast = 1'b0;
        repeat (2) @(negedge clk); fast = 1'b1;
        repeat (6) @(negedge clk); energy = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 valid after retrigger in count", valid, 1);
        check("R8 rise unaffected by retrigger", rise, 10);
        check("R8 stamp from first start", stamp, n + 2);
        fast = 1'b0;
        repeat (2) @(negedge clk); fast = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 valid kept during hold retrigger", valid, 1);
        check("R8 stamp kept during hold retrigger", stamp, n + 2);
        check("R8 rise kept during hold retrigger", rise, 10);

        // R10: levels still high after release do not retrigger
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        repeat (8) @(negedge clk);
        check("R10 no retrigger valid", valid, 0);
        check("R10 no retrigger stamp", stamp, 0);
        fast = 1'b0; energy = 1'b0;
        repeat (4) @(negedge clk);

        summary();
        $finish;
    end
endmodule